// File: doc/BRIEF.md
# Double-Data-Rate Nibble Link Transmitter

This block moves 128-bit quad-words across a point-to-point link that is four data bits wide. A writer, either a processor core or a DMA engine, hands quad-words over through a valid/ready handshake into a two-entry transmit store. The block then sends each stored quad-word as 32 nibbles, least significant first. It also generates the link clock itself, and data changes on both of that clock's edges. Each system clock cycle carries one nibble, so a quad-word takes 16 link clock periods.

A receiver acknowledge input throttles the link. A new quad-word starts only when acknowledge is high at a quad-word boundary. A quad-word that has already started always runs to its end. The writer can mark a quad-word as the final one of a block. While that quad-word is on the link, a block-complete output is high. When nothing is being sent, the link clock and the data lines are held at zero. The differential pairs of a real link are modelled here as single-ended signals.

Top module: `nibble_link_tx`

## Requirements
- R1: After reset, and in every cycle in which no quad-word is on the link, `linkClk`, `linkData` and `blkDone` are 0. `wrReady` is 1 after reset.
- R2: A quad-word is sent as 32 consecutive nibbles, one per system clock cycle. Nibble k equals `wrData[4k+3:4k]`, and nibble 0 comes first.
- R3: `linkClk` is 1 during even-numbered nibbles and 0 during odd-numbered ones. Nibble 0 therefore appears with a rising link clock edge, and a quad-word spans 16 link clock periods.
- R4: If a second quad-word is stored and `ackIn` is high in the last nibble cycle of the current one, the second quad-word's nibble 0 follows in the very next cycle, with no gap.
- R5: A new quad-word starts only if `ackIn` was high at the clock edge that starts it. From idle, raising `ackIn` with a quad-word stored puts nibble 0 on the link one cycle later.
- R6: Once nibble 0 of a quad-word is sent, all 32 nibbles are sent without pause, whatever `ackIn` does.
- R7: `wrReady` is 0 exactly when both buffer entries hold quad-words that are not yet fully sent. Two quad-words can be accepted while the link is stalled.
- R8: `blkDone` is 1 in all 32 nibble cycles of a quad-word that was written with `wrLast` = 1, and 0 in the nibble cycles of any other quad-word.
- R9: Quad-words leave the block in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one nibble per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wrValid | input | 1 | Writer offers a quad-word |
| wrData | input | QW_W | Quad-word to send |
| wrLast | input | 1 | Offered quad-word ends a block |
| wrReady | output | 1 | Transmit store can accept a quad-word |
| ackIn | input | 1 | Receiver acknowledge; permits a new quad-word |
| linkClk | output | 1 | Generated link clock |
| linkData | output | NIB_W | Link data nibble |
| blkDone | output | 1 | High while the final quad-word of a block is sent |

## Verification
The assertions assume that the writer holds `wrData` and `wrLast` steady while `wrValid` is high and `wrReady` is low. They also assume that `ackIn` changes only between clock edges. The bench drives every input at the falling edge and keeps an offer in place until the rising edge accepts it. It raises and lowers `ackIn` only at falling edges, including in the middle of a quad-word, so that R6 is exercised without breaking those assumptions.

// File: rtl/nlt_pkg.sv
package nlt_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic push;    // store the offered quad-word
    logic pop;     // head entry fully sent, advance
    logic wrSlot;  // entry index written on push (after pop)
  } nltStrobe_t;

endpackage

// File: rtl/nlt_ctrl.sv
module nlt_ctrl
  import nlt_pkg::*;
#(
  parameter int NIBS = 32,
  localparam int IW = $clog2(NIBS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrValid,
  input  logic          ackIn,
  output logic          wrReady,
  output logic          busy,
  output logic          linkClk,
  output logic [IW-1:0] nibIdx,
  output nltStrobe_t    strobe
);

  logic [1:0] count;
  logic [1:0] afterPop;
  logic       endQw;
  logic       startNow;
  logic       push;
  logic       pop;

  assign endQw    = busy && (nibIdx == IW'(NIBS - 1));
  assign wrReady  = (count != 2'd2);
  assign push     = wrValid && wrReady;
  assign pop      = endQw;
  assign afterPop = count - {1'b0, pop};

  // a new quad-word begins from idle, or directly after the current one
  assign startNow = ackIn && ((!busy && count != 2'd0) ||
                              (endQw && count == 2'd2));

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= 2'd0;
      busy   <= 1'b0;
      nibIdx <= '0;
    end else begin
      count <= afterPop + {1'b0, push};
      if (startNow) begin
        busy   <= 1'b1;
        nibIdx <= '0;
      end else if (endQw) begin
        busy   <= 1'b0;
        nibIdx <= '0;
      end else if (busy) begin
        nibIdx <= nibIdx + 1'b1;
      end
    end
  end

  assign linkClk = busy && !nibIdx[0];

  always_comb begin
    strobe.push   = push;
    strobe.pop    = pop;
    strobe.wrSlot = afterPop[0];
  end

endmodule

// File: rtl/nlt_datapath.sv
module nlt_datapath
  import nlt_pkg::*;
#(
  parameter int QW_W  = 128,
  parameter int NIB_W = 4,
  localparam int NIBS = QW_W / NIB_W,
  localparam int IW   = $clog2(NIBS)
) (
  input  logic             clk,
  input  logic             rst,
  input  nltStrobe_t       strobe,
  input  logic [QW_W-1:0]  wrData,
  input  logic             wrLast,
  input  logic             busy,
  input  logic [IW-1:0]    nibIdx,
  output logic [NIB_W-1:0] linkData,
  output logic             blkDone
);

  logic [QW_W-1:0]  slotData [2];
  logic             slotLast [2];
  logic [NIB_W-1:0] nibs [NIBS];

  // entry 0 is the head; pop shifts, then push may overwrite
  always_ff @(posedge clk) begin
    if (rst) begin
      slotData[0] <= '0;
      slotData[1] <= '0;
      slotLast[0] <= 1'b0;
      slotLast[1] <= 1'b0;
    end else begin
      if (strobe.pop) begin
        slotData[0] <= slotData[1];
        slotLast[0] <= slotLast[1];
      end
      if (strobe.push) begin
        slotData[strobe.wrSlot] <= wrData;
        slotLast[strobe.wrSlot] <= wrLast;
      end
    end
  end

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nibs[g] = slotData[0][g*NIB_W +: NIB_W];
  end

  assign linkData = busy ? nibs[nibIdx] : '0;
  assign blkDone  = busy && slotLast[0];

endmodule

// File: rtl/nibble_link_tx.sv
module nibble_link_tx
  import nlt_pkg::*;
#(
  parameter int QW_W  = 128,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrValid,
  input  logic [QW_W-1:0]  wrData,
  input  logic             wrLast,
  output logic             wrReady,
  input  logic             ackIn,
  output logic             linkClk,
  output logic [NIB_W-1:0] linkData,
  output logic             blkDone
);

  localparam int NIBS = QW_W / NIB_W;
  localparam int IW   = $clog2(NIBS);

  nltStrobe_t    strobe;
  logic          busy;
  logic [IW-1:0] nibIdx;

  nlt_ctrl #(.NIBS(NIBS)) u_ctrl (
    .clk(clk), .rst(rst), .wrValid(wrValid), .ackIn(ackIn),
    .wrReady(wrReady), .busy(busy), .linkClk(linkClk),
    .nibIdx(nibIdx), .strobe(strobe)
  );

  nlt_datapath #(.QW_W(QW_W), .NIB_W(NIB_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .wrLast(wrLast), .busy(busy), .nibIdx(nibIdx),
    .linkData(linkData), .blkDone(blkDone)
  );

endmodule

// File: rtl/nlt_chk.sv
module nlt_chk #(
  parameter int QW_W  = 128,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wrValid,
  input logic             wrReady,
  input logic             ackIn,
  input logic             linkClk,
  input logic [NIB_W-1:0] linkData,
  input logic             blkDone
);

  localparam int PERIODS = QW_W / NIB_W / 2;
  localparam int PW = $clog2(PERIODS);

  // link clock periods already started within the current quad-word
  logic [PW-1:0] per;
  always_ff @(posedge clk) begin
    if (rst) per <= '0;
    else if (linkClk) per <= (per == PW'(PERIODS - 1)) ? '0 : per + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!linkClk && !$past(linkClk)) |-> (linkData == '0 && !blkDone));

  // R3
  clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(linkClk) |-> !linkClk);

  // R6
  no_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (per != '0 && !linkClk) |=> linkClk);

  // R5
  start_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (linkClk && per == '0) |-> $past(ackIn));

  // R8
  blk_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!linkClk && $past(linkClk)) |-> $stable(blkDone));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wrReady) |-> $past(wrValid));

endmodule

bind nibble_link_tx nlt_chk #(.QW_W(QW_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .wrValid(wrValid), .wrReady(wrReady),
  .ackIn(ackIn), .linkClk(linkClk), .linkData(linkData), .blkDone(blkDone)
);

// File: tb/sim_nibble_link_tx.sv
`timescale 1ns/1ps
module sim_nibble_link_tx;

  localparam int QW_W = 128;
  localparam int NIB_W = 4;
  localparam int NIBS = QW_W / NIB_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrValid = 1'b0;
  logic [QW_W-1:0] wrData = '0;
  logic wrLast = 1'b0;
  logic wrReady;
  logic ackIn = 1'b0;
  logic linkClk;
  logic [NIB_W-1:0] linkData;
  logic blkDone;

  always #2.5 clk = ~clk;

  nibble_link_tx #(.QW_W(QW_W), .NIB_W(NIB_W)) u0 (.*);

  int checks = 0;
  int errors = 0;

  logic [QW_W-1:0] expData [0:63];
  logic expLast [0:63];
  int wrIdx = 0;
  int rdIdx = 0;
  int qwStart [0:63];
  int cyc = 0;
  int actCycles = 0;

  task automatic check(input bit ok, input string tag, input logic [QW_W-1:0] act,
                       input logic [QW_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: sampled at falling edges
  logic prevClk = 1'b0;
  int nibPos = 0;
  logic [QW_W-1:0] acc = '0;
  bit blkBad = 0;
  bit clkBad = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (linkClk || prevClk) begin
        actCycles++;
        if (nibPos == 0) begin
          qwStart[rdIdx] = cyc;
          blkBad = 0;
          clkBad = 0;
        end
        acc[nibPos*NIB_W +: NIB_W] = linkData;
        if (blkDone !== expLast[rdIdx]) blkBad = 1;
        if (linkClk !== ((nibPos % 2) == 0)) clkBad = 1;
        if (nibPos == NIBS - 1) begin
          check(acc === expData[rdIdx], "R2/R9 quad-word content", acc, expData[rdIdx]);
          check(!blkBad, "R8 block-complete per nibble", QW_W'(blkDone), QW_W'(expLast[rdIdx]));
          check(!clkBad, "R3 link clock phase", QW_W'(clkBad), '0);
          rdIdx++;
          nibPos = 0;
        end else begin
          nibPos++;
        end
      end else if (linkData !== '0 || blkDone !== 1'b0) begin
        check(0, "R1 idle lines", QW_W'({blkDone, linkData}), '0);
      end
      prevClk = linkClk;
    end
  end

  // entered and left at a falling edge
  task automatic writeQw(input logic [QW_W-1:0] d, input logic l);
    wrValid = 1'b1;
    wrData = d;
    wrLast = l;
    expData[wrIdx] = d;
    expLast[wrIdx] = l;
    wrIdx++;
    while (!wrReady) @(negedge clk);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitDrain();
    int t = 0;
    while (rdIdx != wrIdx && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(rdIdx == wrIdx, "R9 all quad-words delivered", QW_W'(rdIdx), QW_W'(wrIdx));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int act0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 / R7 reset state
    check(linkClk === 1'b0, "R1 reset linkClk", QW_W'(linkClk), '0);
    check(linkData === '0, "R1 reset linkData", QW_W'(linkData), '0);
    check(blkDone === 1'b0, "R1 reset blkDone", QW_W'(blkDone), '0);
    check(wrReady === 1'b1, "R7 reset wrReady", QW_W'(wrReady), 1);

    // sweep: one nonzero nibble per position, then dense patterns (R2, R8, R4)
    ackIn = 1'b1;
    for (int i = 0; i < NIBS; i++) begin
      logic [QW_W-1:0] d;
      d = '0;
      d[i*NIB_W +: NIB_W] = NIB_W'((i % 15) + 1);
      writeQw(d, (i % 8) == 7);
    end
    for (int i = 0; i < 8; i++) begin
      logic [QW_W-1:0] d;
      for (int k = 0; k < NIBS; k++) d[k*NIB_W +: NIB_W] = NIB_W'(k * (i + 3) + i);
      writeQw(d, i == 7);
    end
    waitDrain();
    // R4: consecutive quad-words with no gap
    for (int k = 0; k < wrIdx - 1; k++)
      check(qwStart[k+1] - qwStart[k] == NIBS, "R4 back-to-back spacing",
            QW_W'(qwStart[k+1] - qwStart[k]), QW_W'(NIBS));

    // R5 / R7 stall with acknowledge low
    ackIn = 1'b0;
    waitCycles(3);
    base = rdIdx;
    act0 = actCycles;
    writeQw({4{32'hA5C3_0F1E}}, 1'b1);
    check(wrReady === 1'b1, "R7 ready with one entry", QW_W'(wrReady), 1);
    writeQw({4{32'h1357_9BDF}}, 1'b0);
    check(wrReady === 1'b0, "R7 not ready with two entries", QW_W'(wrReady), 0);
    waitCycles(40);
    check(actCycles == act0, "R5 no start while ack low", QW_W'(actCycles - act0), 0);
    // raise ack: nibble 0 one cycle later
    ackIn = 1'b1;
    @(negedge clk);
    check(linkClk === 1'b1, "R5 start after ack rises", QW_W'(linkClk), 1);
    // R6: drop ack mid quad-word
    waitCycles(4);
    ackIn = 1'b0;
    waitCycles(80);
    check(rdIdx == base + 1, "R6 started quad-word completes", QW_W'(rdIdx), QW_W'(base + 1));
    check(actCycles - act0 == NIBS, "R5 second held by ack low", QW_W'(actCycles - act0), QW_W'(NIBS));
    check(wrReady === 1'b1, "R7 ready after one sent", QW_W'(wrReady), 1);
    ackIn = 1'b1;
    waitDrain();
    waitCycles(5);
    check(linkClk === 1'b0 && linkData === '0, "R1 idle after drain",
          QW_W'({linkClk, linkData}), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule